// File: doc/BRIEF.md
# Progressive Gauss-Jordan Network Decoder

This block recovers a generation of source packets from coded packets built as random linear combinations over GF(2^8). Each coded packet arrives in one beat: one coefficient per source packet and a payload of coded symbols. The block holds a small augmented matrix, with one row slot per source packet. Every arriving row is reduced against the rows already held as soon as it is accepted. This keeps the stored matrix in reduced form at all times, so that no separate solve pass is needed once enough packets have been received.

A reduced row whose coefficients are all zero adds nothing new. It is dropped and a one-cycle indication is raised. Any other reduced row is scaled so that its leading coefficient becomes one. The inverse for that scaling comes from a 256-entry table filled at elaboration. The new pivot column is then cleared out of every stored row, and the row is filed in the slot of its pivot column. When all slots are filled, the coefficient part is the identity. The block then streams the payloads in source order under a valid/ready handshake. After the last symbol has been transferred, the block empties itself for the next generation.

Top module: `ncd_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `rank` is 0, `done`, `out_valid` and `dep_drop` are low, and `in_ready` is high.
- R2: A row that is linearly independent of the stored rows is taken in on a cycle where `in_valid` and `in_ready` are both high. `rank` rises by exactly one on the 2N+2-th rising edge after that cycle, where N is `NPKT`. `in_ready` stays low until that edge.
- R3: A row that is linearly dependent on the stored rows is dropped. This includes a row whose coefficients are all zero. `dep_drop` is high for exactly one cycle, after the N+1-th edge following acceptance. `in_ready` returns high in that same cycle, and `rank` is unchanged.
- R4: Once `rank` reaches N, `done` is high, `in_ready` is low and `out_valid` is high.
- R5: The field is GF(2^8) with reduction polynomial x^8+x^4+x^3+x^2+1 (0x11D). The coefficient for source packet k sits in `in_coef[8k+7:8k]`, and coded payload symbol j sits in `in_pay[8j+7:8j]`. Coded symbol j equals the field sum over k of c_k times source symbol j of packet k. The output symbols equal the source symbols, ordered by packet 0 to N-1 and, within a packet, by symbol 0 to PAY_SYMS-1. This holds whatever the arrival order and mixing of the coded rows.
- R6: `out_pkt` carries the source index of the current symbol. `out_last` is high on the final symbol of every packet.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_pkt` and `out_last` hold their values.
- R8: In the cycle after the final symbol of packet N-1 has been transferred, `rank` is 0, `done` is low and `in_ready` is high. A following generation then decodes independently of the previous one.
- R9: `in_ready` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A coded row is offered |
| in_ready | output | 1 | Block can take a coded row |
| in_coef | input | NPKT*8 | Coding coefficients, source k in byte k |
| in_pay | input | PAY_SYMS*8 | Coded payload, symbol j in byte j |
| out_valid | output | 1 | A decoded symbol is offered |
| out_ready | input | 1 | Consumer takes the decoded symbol |
| out_data | output | 8 | Decoded payload symbol |
| out_pkt | output | $clog2(NPKT) | Source packet index of out_data |
| out_last | output | 1 | Final symbol of the current packet |
| rank | output | $clog2(NPKT+1) | Number of independent rows stored |
| done | output | 1 | Generation fully decoded, output phase |
| dep_drop | output | 1 | One-cycle pulse for a dropped dependent row |

## Verification
Every accepted row has a fixed latency, so the bench counts falling edges from the acceptance edge. For a dependent row it expects `in_ready` and the `dep_drop` pulse at count N+1. For an independent row it expects the new `rank` at count 2N+2. Any other arrival time is reported, together with the count at which the event was actually seen. Output symbols are sampled on the falling edge while `out_valid` is high. The consumer holds `ready` low for two cycles on some beats to observe the hold behaviour. The empty state is checked on the first falling edge after the final transfer.

// File: rtl/ncd_pkg.sv
// Package: field arithmetic and controller state shared by the decoder.
// Assumes GF(2^8) with reduction polynomial 0x11D, standard basis.
package ncd_pkg;

    localparam logic [7:0] GF_POLY_LOW = 8'h1D;

    // Carry-less product followed by polynomial reduction, single cycle.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [14:0] prod;
        prod = '0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) prod = prod ^ (15'(a) << i);
        end
        for (int i = 14; i >= 8; i--) begin
            if (prod[i]) prod = prod ^ (15'({1'b1, GF_POLY_LOW}) << (i - 8));
        end
        return prod[7:0];
    endfunction

    // Inverse as a^254, used only to fill the lookup table at elaboration.
    function automatic logic [7:0] gf_inv_calc(input logic [7:0] a);
        logic [7:0] acc;
        logic [7:0] base;
        acc  = 8'h01;
        base = a;
        for (int i = 0; i < 8; i++) begin
            if (i != 0) acc = gf_mul(acc, base);
            base = gf_mul(base, base);
        end
        return acc;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REDUCE,
        ST_NORM,
        ST_ELIM,
        ST_COMMIT,
        ST_EMIT
    } ncd_state_e;

endpackage

// File: rtl/ncd_inv_lut.sv
// Module: 256-entry field inverse table, contents computed at elaboration.
// Assumes entry 0 maps to 0; callers never use it on a pivot.
module ncd_inv_lut (
    input  logic [7:0] elem,
    output logic [7:0] recip
);
    logic [7:0] inv_tab [256];

    // Fill each entry from the constant inverse function.
    for (genvar gi = 0; gi < 256; gi++) begin : g_entry
        localparam logic [7:0] ENTRY_VAL = ncd_pkg::gf_inv_calc(8'(gi));
        assign inv_tab[gi] = ENTRY_VAL;
    end

    // Table read.
    assign recip = inv_tab[elem];
endmodule

// File: rtl/ncd_vec_axpy.sv
// Module: lane-parallel result = acc + scale * src over GF(2^8).
// Assumes all lanes share one scale factor; purely combinational.
module ncd_vec_axpy #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0][7:0] acc,
    input  logic [7:0]            scale,
    input  logic [LANES-1:0][7:0] src,
    output logic [LANES-1:0][7:0] result
);
    // One multiplier and XOR per lane.
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        assign result[gl] = acc[gl] ^ ncd_pkg::gf_mul(scale, src[gl]);
    end
endmodule

// File: rtl/ncd_pivot_find.sv
// Module: locates the lowest-index nonzero coefficient of a row.
// Assumes NPKT >= 2; found is low for an all-zero coefficient vector.
module ncd_pivot_find #(
    parameter int NPKT = 4,
    parameter int IW   = 2
) (
    input  logic [NPKT-1:0][7:0] coef,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    // Priority scan from the top so the lowest nonzero index wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NPKT - 1; i >= 0; i--) begin
            if (coef[i] != 8'h00) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/ncd_decoder.sv
// Module: progressive Gauss-Jordan decoder over GF(2^8).
// Each accepted row is reduced against stored pivot rows, normalised,
// cleared out of stored rows and filed under its pivot column. At full
// rank the stored payloads are the sources and are streamed in order.
// Assumes 2 <= NPKT <= 8 and PAY_SYMS >= 2; rows arrive one per beat.
module ncd_decoder #(
    parameter int NPKT     = 4,
    parameter int PAY_SYMS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [NPKT*8-1:0]             in_coef,
    input  logic [PAY_SYMS*8-1:0]         in_pay,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [7:0]                    out_data,
    output logic [$clog2(NPKT)-1:0]       out_pkt,
    output logic                          out_last,
    output logic [$clog2(NPKT+1)-1:0]     rank,
    output logic                          done,
    output logic                          dep_drop
);
    import ncd_pkg::*;

    localparam int W  = NPKT + PAY_SYMS;
    localparam int IW = $clog2(NPKT);
    localparam int SW = $clog2(PAY_SYMS);
    localparam int RW = $clog2(NPKT + 1);
    localparam int LW = $clog2(W);

    typedef logic [W-1:0][7:0] lane_vec_t;

    ncd_state_e          state_q;
    lane_vec_t           work_q;
    lane_vec_t           rows_q [NPKT];
    logic [NPKT-1:0]     row_ok_q;
    logic [IW-1:0]       cnt_q;
    logic [IW-1:0]       piv_q;
    logic [RW-1:0]       rank_q;
    logic                dep_q;
    logic [IW-1:0]       opkt_q;
    logic [SW-1:0]       osym_q;

    logic                piv_found;
    logic [IW-1:0]       piv_c;
    logic [7:0]          piv_inv;
    lane_vec_t           ax_acc;
    lane_vec_t           ax_src;
    lane_vec_t           ax_out;
    logic [7:0]          ax_scale;
    logic                cnt_last;
    logic                accept;
    logic                beat;
    logic                final_beat;
    logic [LW-1:0]       pay_lane;

    // Leading nonzero coefficient of the working row.
    ncd_pivot_find #(.NPKT(NPKT), .IW(IW)) u_piv (
        .coef  (work_q[NPKT-1:0]),
        .found (piv_found),
        .idx   (piv_c)
    );

    // Inverse of the pivot value.
    ncd_inv_lut u_inv (
        .elem  (work_q[piv_c]),
        .recip (piv_inv)
    );

    // Shared row operation unit.
    ncd_vec_axpy #(.LANES(W)) u_axpy (
        .acc    (ax_acc),
        .scale  (ax_scale),
        .src    (ax_src),
        .result (ax_out)
    );

    assign cnt_last   = (cnt_q == IW'(NPKT - 1));
    assign in_ready   = (state_q == ST_IDLE);
    assign accept     = in_valid && in_ready;
    assign out_valid  = (state_q == ST_EMIT);
    assign done       = (state_q == ST_EMIT);
    assign beat       = out_valid && out_ready;
    assign out_last   = (osym_q == SW'(PAY_SYMS - 1));
    assign final_beat = beat && out_last && (opkt_q == IW'(NPKT - 1));
    assign pay_lane   = LW'(NPKT) + LW'(osym_q);
    assign out_data   = rows_q[opkt_q][pay_lane];
    assign out_pkt    = opkt_q;
    assign rank       = rank_q;
    assign dep_drop   = dep_q;

    // Select operands of the row operation unit per phase.
    always_comb begin
        ax_acc   = work_q;
        ax_scale = 8'h00;
        ax_src   = rows_q[cnt_q];
        case (state_q)
            ST_REDUCE: begin
                ax_acc   = work_q;
                ax_scale = row_ok_q[cnt_q] ? work_q[cnt_q] : 8'h00;
                ax_src   = rows_q[cnt_q];
            end
            ST_NORM: begin
                ax_acc   = '0;
                ax_scale = piv_inv;
                ax_src   = work_q;
            end
            ST_ELIM: begin
                ax_acc   = rows_q[cnt_q];
                ax_scale = rows_q[cnt_q][piv_q];
                ax_src   = work_q;
            end
            default: begin
                ax_acc   = work_q;
                ax_scale = 8'h00;
                ax_src   = rows_q[cnt_q];
            end
        endcase
    end

    // Phase sequencing and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_REDUCE;
                        cnt_q   <= '0;
                    end
                end
                ST_REDUCE: begin
                    if (cnt_last) begin
                        state_q <= ST_NORM;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + IW'(1);
                    end
                end
                ST_NORM: begin
                    state_q <= piv_found ? ST_ELIM : ST_IDLE;
                    cnt_q   <= '0;
                end
                ST_ELIM: begin
                    if (cnt_last) begin
                        state_q <= ST_COMMIT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + IW'(1);
                    end
                end
                ST_COMMIT: begin
                    state_q <= (rank_q == RW'(NPKT - 1)) ? ST_EMIT : ST_IDLE;
                end
                ST_EMIT: begin
                    if (final_beat) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Working row: load, reduce against pivots, normalise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q <= '0;
        end else if (accept) begin
            work_q <= {in_pay, in_coef};
        end else if (state_q == ST_REDUCE || state_q == ST_NORM) begin
            work_q <= ax_out;
        end
    end

    // Pivot column captured at normalisation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            piv_q <= '0;
        end else if (state_q == ST_NORM) begin
            piv_q <= piv_c;
        end
    end

    // Stored rows: elimination updates, commit and generation release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_ok_q <= '0;
            for (int i = 0; i < NPKT; i++) rows_q[i] <= '0;
        end else begin
            if (state_q == ST_ELIM && row_ok_q[cnt_q]) begin
                rows_q[cnt_q] <= ax_out;
            end
            if (state_q == ST_COMMIT) begin
                rows_q[piv_q]   <= work_q;
                row_ok_q[piv_q] <= 1'b1;
            end
            if (final_beat) begin
                row_ok_q <= '0;
            end
        end
    end

    // Rank counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q <= '0;
        end else if (final_beat) begin
            rank_q <= '0;
        end else if (state_q == ST_COMMIT) begin
            rank_q <= rank_q + RW'(1);
        end
    end

    // Dependent-row pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dep_q <= 1'b0;
        end else begin
            dep_q <= (state_q == ST_NORM) && !piv_found;
        end
    end

    // Output packet and symbol position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opkt_q <= '0;
            osym_q <= '0;
        end else if (beat) begin
            if (out_last) begin
                osym_q <= '0;
                opkt_q <= (opkt_q == IW'(NPKT - 1)) ? '0 : opkt_q + IW'(1);
            end else begin
                osym_q <= osym_q + SW'(1);
            end
        end
    end
endmodule

// File: rtl/ncd_checker.sv
// Module: protocol and rank properties of the decoder, bound to its ports.
// Assumes synchronous active-low reset held for at least one edge.
module ncd_checker #(
    parameter int NPKT     = 4,
    parameter int PAY_SYMS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_ready,
    input logic                      out_valid,
    input logic                      out_ready,
    input logic [7:0]                out_data,
    input logic [$clog2(NPKT)-1:0]   out_pkt,
    input logic                      out_last,
    input logic [$clog2(NPKT+1)-1:0] rank,
    input logic                      done,
    input logic                      dep_drop
);
    localparam int IW = $clog2(NPKT);
    localparam int RW = $clog2(NPKT + 1);

    // R1: first cycle after reset is empty
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rank == '0 && !out_valid && !dep_drop && in_ready));

    // R2: rank only steps by one or clears
    p_rank_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rank != $past(rank)) |-> (rank == $past(rank) + RW'(1) || rank == '0));

    // R3: drop pulse lasts one cycle
    p_dep_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dep_drop |=> !dep_drop);

    // R3: drop leaves rank unchanged
    p_dep_rank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dep_drop |-> $stable(rank));

    // R4: done only at full rank and with input closed
    p_done_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rank == RW'(NPKT) && !in_ready && out_valid));

    // R7: output held under backpressure
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_pkt) && $stable(out_last)));

    // R8: final transfer empties the block
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && out_pkt == IW'(NPKT - 1)) |=>
            (rank == '0 && !done && in_ready));

    // R9: input and output phases exclusive
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
endmodule

bind ncd_decoder ncd_checker #(.NPKT(NPKT), .PAY_SYMS(PAY_SYMS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_pkt   (out_pkt),
    .out_last  (out_last),
    .rank      (rank),
    .done      (done),
    .dep_drop  (dep_drop)
);

// File: tb/ncd_decoder_tb.sv
// Bench: encodes random sources with chosen coefficient rows, injects
// dependent rows, checks latency, rank and recovered data.
module ncd_decoder_tb;
    localparam int NP = 4;
    localparam int PS = 4;
    localparam int IW = $clog2(NP);
    localparam int RW = $clog2(NP + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [NP*8-1:0]   in_coef = '0;
    logic [PS*8-1:0]   in_pay = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [7:0]        out_data;
    logic [IW-1:0]     out_pkt;
    logic              out_last;
    logic [RW-1:0]     rank;
    logic              done;
    logic              dep_drop;

    int checks = 0;
    int fails  = 0;
    int exp_rank = 0;
    logic [7:0] src [NP][PS];

    always #10 clk = ~clk;

    ncd_decoder #(.NPKT(NP), .PAY_SYMS(PS)) u_dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_coef (in_coef), .in_pay (in_pay),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_data (out_data), .out_pkt (out_pkt), .out_last (out_last),
        .rank (rank), .done (done), .dep_drop (dep_drop)
    );

    // Shift-and-add field product, polynomial 0x11D.
    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r  = 8'h00;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        for (int i = 0; i < 8; i++) begin
            logic hi;
            if (bb[0]) r = r ^ aa;
            hi = aa[7];
            aa = aa << 1;
            if (hi) aa = aa ^ 8'h1D;
            bb = bb >> 1;
        end
        return r;
    endfunction

    function automatic logic [NP*8-1:0] mix(input logic [7:0] a, input logic [NP*8-1:0] ca,
                                            input logic [7:0] b, input logic [NP*8-1:0] cb);
        logic [NP*8-1:0] r;
        for (int l = 0; l < NP; l++) r[8*l +: 8] = bmul(a, ca[8*l +: 8]) ^ bmul(b, cb[8*l +: 8]);
        return r;
    endfunction

    function automatic logic [PS*8-1:0] encode(input logic [NP*8-1:0] c);
        logic [PS*8-1:0] r = '0;
        for (int j = 0; j < PS; j++)
            for (int k = 0; k < NP; k++)
                r[8*j +: 8] = r[8*j +: 8] ^ bmul(c[8*k +: 8], src[k][j]);
        return r;
    endfunction

    function automatic logic [NP*8-1:0] unit(input int k);
        logic [NP*8-1:0] r = '0;
        r[8*k +: 8] = 8'h01;
        return r;
    endfunction

    // Triangular row: zero below i, nonzero at i, random above.
    function automatic logic [NP*8-1:0] tri_row(input int i);
        logic [NP*8-1:0] r = '0;
        for (int l = 0; l < NP; l++) begin
            if (l == i) r[8*l +: 8] = 8'(($urandom % 255) + 1);
            else if (l > i) r[8*l +: 8] = 8'($urandom);
        end
        return r;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic new_sources();
        for (int k = 0; k < NP; k++)
            for (int j = 0; j < PS; j++) src[k][j] = 8'($urandom);
    endtask

    // Offer one coded row and time its outcome in falling edges.
    task automatic send(input logic [NP*8-1:0] c, input bit is_dep);
        int cyc = 0;
        int deps = 0;
        int dep_at = -1;
        while (!in_ready) @(negedge clk);
        in_coef  = c;
        in_pay   = encode(c);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!(in_ready || out_valid) && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (dep_drop) begin
                deps++;
                dep_at = cyc;
            end
        end
        if (is_dep) begin
            chk("R3 dep pulse count", deps, 1);
            chk("R3 dep pulse cycle", dep_at, NP + 1);
            chk("R3 ready latency", cyc, NP + 1);
            chk("R3 rank kept", int'(rank), exp_rank);
        end else begin
            exp_rank++;
            chk("R2 no dep pulse", deps, 0);
            chk("R2 commit latency", cyc, 2 * NP + 2);
            chk("R2 rank step", int'(rank), exp_rank);
        end
        if (exp_rank == NP) begin
            chk("R4 done", int'(done), 1);
            chk("R4 input closed", int'(in_ready), 0);
            chk("R4 output open", int'(out_valid), 1);
        end
    endtask

    // Take all decoded symbols, optionally with stalls.
    task automatic drain(input bit stall);
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < PS; s++) begin
                while (!out_valid) @(negedge clk);
                if (stall && ($urandom % 2 == 0)) begin
                    logic [7:0] held = out_data;
                    repeat (2) @(negedge clk);
                    chk("R7 valid held", int'(out_valid), 1);
                    chk("R7 data held", int'(out_data), int'(held));
                end
                chk("R5 symbol", int'(out_data), int'(src[p][s]));
                chk("R6 packet index", int'(out_pkt), p);
                chk("R6 last flag", int'(out_last), (s == PS - 1) ? 1 : 0);
                chk("R9 input closed", int'(in_ready), 0);
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
        end
        exp_rank = 0;
        chk("R8 rank cleared", int'(rank), 0);
        chk("R8 done cleared", int'(done), 0);
        chk("R8 input open", int'(in_ready), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        logic [NP*8-1:0] ta, tb, tc, td;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R1 rank in reset", int'(rank), 0);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rank", int'(rank), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 dep", int'(dep_drop), 0);
        chk("R1 ready", int'(in_ready), 1);

        // Generation 0: unit rows out of order, duplicates and zero row.
        new_sources();
        send(unit(3), 1'b0);
        send(unit(3), 1'b1);
        send('0, 1'b1);
        send(unit(1), 1'b0);
        send(unit(0), 1'b0);
        send(mix(8'h03, unit(1), 8'h01, unit(0)), 1'b1);
        send(unit(2), 1'b0);
        drain(1'b0);

        // Generations 1 and 2: dense mixed rows plus a dependent mix.
        for (int g = 1; g <= 2; g++) begin
            new_sources();
            ta = tri_row(2);
            tb = mix(8'h01, tri_row(0), 8'h09, ta);
            send(ta, 1'b0);
            send(tb, 1'b0);
            send(mix(8'h53, ta, 8'hCA, tb), 1'b1);
            tc = tri_row(3);
            td = mix(8'h01, tri_row(1), 8'h07, tc);
            send(tc, 1'b0);
            send(mix(8'h01, tc, 8'h2F, ta), 1'b1);
            send(td, 1'b0);
            drain(g == 2);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule